// File: doc/BRIEF.md
# Combo PHY Configuration Register with Indirect Test-Port Bridge

This block is the single 32-bit configuration word that sits in front of a multi-protocol serial PHY. Two of its bits drive the PHY directly. One bypasses the line codec, and clearing it turns encoding and decoding on. The other enables the reference clock driven out to the attached endpoint. The block also carries a 2-bit protocol-select output, loaded through its own write port.

Inside the same word there is a narrow indirect test port into a small array of internal PHY registers. Software places a 5-bit address and a 4-bit value in their fields. It first writes the word with the strobe bit low, then writes it again with the strobe bit high. Only that low-to-high change of the strobe between two successive register writes stores the value into the array. A separate read address returns any array entry one cycle later.

Top module: `combo_phy_cfg`

## Requirements
- R1: While reset is held and right after it is released, the config word reads 0, `codec_bypass` and `refclk_oe` are 0, `proto_sel` is 0 and every internal array entry reads 0.
- R2: A bus write (`cfg_we`=1) replaces all 32 bits of the config word. `cfg_rdata` shows the written value from the next clock edge onward. With `cfg_we`=0 the word holds its value.
- R3: `codec_bypass` follows bit 31 of the config word.
- R4: `refclk_oe` follows bit 0 of the config word.
- R5: A bus write that sets bit 24 (the strobe) while the stored bit 24 is 0 commits data bits 23:20 into the array entry addressed by bits 16:12, both taken from that same write.
- R6: A bus write whose bit 24 is 0 commits nothing. A write with bit 24 high when the stored bit 24 is already 1 also commits nothing.
- R7: `tp_rdata` returns the array entry at `tp_raddr` one clock edge after the address is presented.
- R8: A protocol-select write (`sel_we`=1) with code 0 (PCIe), 1 (USB3) or 2 (SATA) loads `proto_sel` at the next edge. Code 3 is rejected and `proto_sel` keeps its previous value.
- R9: Bits 30:25, 19:17 and 11:1 of the config word read back as written but affect no output and no array entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config word write enable |
| cfg_wdata | input | 32 | Config word write value |
| cfg_rdata | output | 32 | Config word readback |
| sel_we | input | 1 | Protocol-select write enable |
| sel_code | input | 2 | Protocol code: 0 PCIe, 1 USB3, 2 SATA, 3 invalid |
| proto_sel | output | 2 | Current protocol select |
| codec_bypass | output | 1 | Line codec bypass |
| refclk_oe | output | 1 | Reference clock output enable |
| tp_raddr | input | 5 | Test array read address |
| tp_rdata | output | 4 | Test array read data, one cycle latency |

## Verification
The config word, the two control outputs, the protocol select and any array commit all take effect at the first clock edge after the write is sampled. Array readback needs one more edge after the read address. The bench drives each input on a falling edge. It samples the directly driven outputs on the next falling edge. For array contents it first presents the read address and then waits one full cycle before comparing, so a commit and its readback never fall on the same edge. The expected array contents come from a shadow array in the bench, which is updated only when the bench itself issues a low-to-high strobe pair.

// File: rtl/combo_phy_cfg.sv
module combo_phy_cfg #(
  parameter int AW = 5,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          sel_we,
  input  logic [1:0]    sel_code,
  output logic [1:0]    proto_sel,
  output logic          codec_bypass,
  output logic          refclk_oe,
  input  logic [AW-1:0] tp_raddr,
  output logic [DW-1:0] tp_rdata
);
  localparam int DEPTH   = 1 << AW;
  localparam int BYP_BIT = 31;
  localparam int STB_BIT = 24;
  localparam int DAT_LO  = 20;
  localparam int ADR_LO  = 12;
  localparam int OE_BIT  = 0;

  logic [31:0]   cfg_q;
  logic [DW-1:0] arr [DEPTH];
  logic          commit;
  logic [AW-1:0] wa;
  logic [DW-1:0] wd;

  assign commit       = cfg_we && cfg_wdata[STB_BIT] && !cfg_q[STB_BIT];
  assign wa           = cfg_wdata[ADR_LO +: AW];
  assign wd           = cfg_wdata[DAT_LO +: DW];
  assign cfg_rdata    = cfg_q;
  assign codec_bypass = cfg_q[BYP_BIT];
  assign refclk_oe    = cfg_q[OE_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) proto_sel <= 2'd0;
    else if (sel_we && sel_code != 2'd3) proto_sel <= sel_code;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) arr[i] <= '0;
    end else if (commit) begin
      arr[wa] <= wd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tp_rdata <= '0;
    else tp_rdata <= arr[tp_raddr];
  end
endmodule

module combo_phy_cfg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        sel_we,
  input logic [1:0]  sel_code,
  input logic [1:0]  proto_sel,
  input logic        codec_bypass,
  input logic        refclk_oe
);
  p_word_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));
  p_word_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));
  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> codec_bypass == $past(cfg_wdata[31]));
  p_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> refclk_oe == $past(cfg_wdata[0]));
  p_sel_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && sel_code != 2'd3) |=> proto_sel == $past(sel_code));
  p_sel_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && sel_code == 2'd3) |=> $stable(proto_sel));
  p_sel_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_sel != 2'd3);
endmodule

bind combo_phy_cfg combo_phy_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .sel_we(sel_we), .sel_code(sel_code),
  .proto_sel(proto_sel), .codec_bypass(codec_bypass), .refclk_oe(refclk_oe)
);

// File: tb/sim_combo_phy_cfg.sv
module sim_combo_phy_cfg;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        sel_we = 0;
  logic [1:0]  sel_code = '0;
  logic [1:0]  proto_sel;
  logic        codec_bypass, refclk_oe;
  logic [4:0]  tp_raddr = '0;
  logic [3:0]  tp_rdata;

  int n_chk = 0, n_bad = 0;
  logic [3:0] shadow [32];
  logic [1:0] exp_sel;

  always #4 clk = ~clk;

  combo_phy_cfg u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  function automatic logic [31:0] word(int a, int d, bit stb);
    return (32'(stb) << 24) | (32'(d & 15) << 20) | (32'(a & 31) << 12);
  endfunction

  task automatic poke(int a, int d);
    wr(word(a, d, 0));
    wr(word(a, d, 1));
    shadow[a] = 4'(d);
  endtask

  task automatic rd_check(string req, int a);
    @(negedge clk); tp_raddr = 5'(a);
    @(negedge clk); check(req, 32'(tp_rdata), 32'(shadow[a]));
  endtask

  task automatic sel(logic [1:0] c);
    @(negedge clk); sel_we = 1; sel_code = c;
    @(negedge clk); sel_we = 0;
    if (c != 2'd3) exp_sel = c;
    check("R8", 32'(proto_sel), 32'(exp_sel));
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) shadow[i] = '0;
    exp_sel = 2'd0;
    repeat (3) @(negedge clk);
    check("R1", cfg_rdata, 32'h0);
    check("R1", 32'(proto_sel), 0);
    check("R1", 32'(codec_bypass), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", 32'({codec_bypass, refclk_oe}), 0);
    for (int a = 0; a < 32; a++) rd_check("R1", a);

    wr(32'h8000_0001);
    check("R2", cfg_rdata, 32'h8000_0001);
    check("R3", 32'(codec_bypass), 1);
    check("R4", 32'(refclk_oe), 1);
    wr(32'h0000_0000);
    check("R3", 32'(codec_bypass), 0);
    check("R4", 32'(refclk_oe), 0);
    repeat (2) @(negedge clk);
    check("R2", cfg_rdata, 32'h0);

    poke(5'h01, 4'h8);
    poke(5'h0c, 4'h9);
    poke(5'h1a, 4'h4);
    rd_check("R5", 5'h01);
    rd_check("R5", 5'h0c);
    rd_check("R5", 5'h1a);

    for (int a = 0; a < 32; a++) poke(a, (a * 7 + 3) & 15);
    for (int a = 0; a < 32; a++) rd_check("R7", a);

    poke(5, 4'hA);
    wr(word(5, 4'h3, 1));
    rd_check("R6", 5);
    wr(word(5, 4'h6, 0));
    rd_check("R6", 5);
    wr(word(6, 4'h1, 0));
    rd_check("R6", 6);

    wr(32'h7E0E_0FFE);
    check("R9", cfg_rdata, 32'h7E0E_0FFE);
    check("R9", 32'({codec_bypass, refclk_oe}), 0);
    for (int a = 0; a < 32; a++) rd_check("R9", a);

    @(negedge clk); tp_raddr = 5'd9;
    @(negedge clk); tp_raddr = 5'd10;
    check("R7", 32'(tp_rdata), 32'(shadow[9]));
    @(negedge clk);
    check("R7", 32'(tp_rdata), 32'(shadow[10]));

    sel(2'd2); sel(2'd3); sel(2'd1); sel(2'd3); sel(2'd0); sel(2'd3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule